// File: doc/BRIEF.md
# Powerline Half-Duplex Transaction Controller

This block runs one end of a single-wire, half-duplex data link that carries short frames between one master and any number of slaves. A host writes up to three payload bytes into transmit registers through a simple register port. It then writes a byte count into a control field, and that write launches a frame. Each byte goes onto the line as a start bit, eight data bits MSB first, an odd-parity bit and a stop bit. The line is open-drain: `lineOut` low pulls the wire down, and `lineOut` high releases it. `lineIn` is the wire as it is seen.

Incoming frames are deserialized into three receive registers. Interrupt flags report the number of bytes received, a missing reply, a collision on the line and a corrupted byte. A mode pin selects the role. A master arms a reply timer after each frame it sends, and it refuses to send again until a reply or a timeout arrives. A slave may only send after it has received a frame. No address filtering is done: every received frame is accepted, and any addressing is carried in the payload.

Top module: `plc_link_ctrl`

## Requirements
- R1: After reset, `lineOut` and `irqN` are high, and the transmit, receive, control and flag registers read 0. The mask register at 0x0C reads 0x1F.
- R2: Registers 0x0D, 0x0E and 0x0F hold transmit bytes 0, 1 and 2 and read back what was written. The receive registers 0x10 to 0x12 ignore writes.
- R3: Writing 0x09 with a nonzero value N in bits 1:0 starts a frame. `lineOut` goes low in the cycle after the write. Bytes 0 to N-1 follow back to back, each as 11 bits of `CLKS_PER_BIT` cycles: low, data MSB first, odd parity, high. Bits 7:2 of 0x09 are stored, and bits 1:0 read back as 0.
- R4: A master refuses any start request while a frame is being sent and while it waits for a reply.
- R5: If no frame arrives within `WAIT_CYCLES` after a master frame ends, bit 0 of 0x0B is set. A new start request is then accepted.
- R6: A slave refuses a start request unless it has received a good frame since its last own frame.
- R7: Received bytes land in 0x10, 0x11 and 0x12 in arrival order. A frame ends after three bytes, or when the line stays high for two bit periods after a stop bit. Bits 2:1 of 0x0B then hold the byte count.
- R8: A byte with wrong parity or a low stop bit sets bit 4 of 0x0B and no byte count.
- R9: If the line reads low in the middle of a bit the block is releasing, bit 3 of 0x0B is set, the frame is aborted and the line is released.
- R10: Reading 0x0B returns the flags and clears them. `irqN` is low while any flag is set whose bit in 0x0C is 1.
- R11: A frame received while a master waits ends the wait. No timeout is flagged, and a new start request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 selects the master role, 0 selects the slave role |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (clears the flags when 0x0B is read) |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| irqN | output | 1 | Active-low interrupt |
| lineIn | input | 1 | Sensed level of the wire |
| lineOut | output | 1 | 0 pulls the wire low, 1 releases it |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 8 and `WAIT_CYCLES` = 600. With these values a three-byte frame lasts 264 cycles and a reply timeout takes a few hundred more. That lets one run cover refusal during the wait, expiry, a reply that ends the wait, collision abort and slave gating. A queue-based model of the expected wire level is compared with `lineOut` on every clock. A peer model drives the wire with correct or corrupted parity to exercise the receive path.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h09;
  localparam logic [7:0] ADDR_IRQ  = 8'h0B;
  localparam logic [7:0] ADDR_MASK = 8'h0C;
  localparam logic [7:0] ADDR_TX0  = 8'h0D;
  localparam logic [7:0] ADDR_RX0  = 8'h10;
  localparam int BYTE_SLOTS = 3;
  localparam int FRAME_BITS = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX, ST_GAP} linkState_t;

  typedef struct packed {
    logic       txStart;
    logic       rxByteVld;
    logic [1:0] rxByteIdx;
    logic [7:0] rxByte;
    logic       rxDone;
    logic [1:0] rxCount;
    logic       rxErr;
    logic       txErr;
    logic       timeout;
  } ctrlStrobe_t;
endpackage

// File: rtl/plc_dp.sv
module plc_dp
  import plc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [7:0]  busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  output logic        irqN,
  input  ctrlStrobe_t st,
  output logic        goReq,
  output logic [1:0]  txCountReq,
  output logic [BYTE_SLOTS-1:0][7:0] txBytes
);
  logic [BYTE_SLOTS-1:0][7:0] rxRegs;
  logic [5:0] cfgReg;
  logic [4:0] flags, flagsNxt, maskReg;
  logic rdIrq;

  assign rdIrq      = busRe && (busAddr == ADDR_IRQ);
  assign goReq      = busWe && (busAddr == ADDR_CTRL) && (busWdata[1:0] != 2'd0);
  assign txCountReq = busWdata[1:0];
  assign irqN       = ~|(flags & maskReg);

  for (genvar i = 0; i < BYTE_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) txBytes[i] <= '0;
      else if (busWe && busAddr == 8'(ADDR_TX0 + i)) txBytes[i] <= busWdata;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rxRegs[i] <= '0;
      else if (st.rxByteVld && st.rxByteIdx == 2'(i)) rxRegs[i] <= st.rxByte;
    end
  end

  always_comb begin
    flagsNxt = rdIrq ? '0 : flags;
    if (st.timeout) flagsNxt[0] = 1'b1;
    if (st.rxDone)  flagsNxt[2:1] = st.rxCount;
    if (st.txErr)   flagsNxt[3] = 1'b1;
    if (st.rxErr)   flagsNxt[4] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      maskReg <= 5'h1F;
      cfgReg  <= '0;
    end else begin
      flags <= flagsNxt;
      if (busWe && busAddr == ADDR_MASK) maskReg <= busWdata[4:0];
      if (busWe && busAddr == ADDR_CTRL) cfgReg <= busWdata[7:2];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_CTRL) busRdata = {cfgReg, 2'b00};
    if (busAddr == ADDR_IRQ)  busRdata = {3'b000, flags};
    if (busAddr == ADDR_MASK) busRdata = {3'b000, maskReg};
    for (int i = 0; i < BYTE_SLOTS; i++) begin
      if (busAddr == 8'(ADDR_TX0 + i)) busRdata = txBytes[i];
      if (busAddr == 8'(ADDR_RX0 + i)) busRdata = rxRegs[i];
    end
  end

  // R3
  go_gate_chk: assert property (@(posedge clk) disable iff (!rstN) st.txStart |-> goReq);
  // R5
  timeout_flag_chk: assert property (@(posedge clk) disable iff (!rstN) st.timeout |=> flags[0]);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIrq && !st.timeout && !st.rxDone && !st.txErr && !st.rxErr) |=> (flags == 5'd0));
endmodule

// File: rtl/plc_ctrl.sv
module plc_ctrl
  import plc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 3000,
  parameter int WAIT_CYCLES  = 1250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        isMaster,
  input  logic        goReq,
  input  logic [1:0]  txCountReq,
  input  logic [BYTE_SLOTS-1:0][7:0] txBytes,
  input  logic        lineIn,
  output logic        lineOut,
  output ctrlStrobe_t st
);
  localparam int CNT_W  = $clog2(2 * CLKS_PER_BIT);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  BIT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0]  HALF      = CNT_W'(CLKS_PER_BIT / 2);
  localparam logic [CNT_W-1:0]  GAP_LAST  = CNT_W'(2 * CLKS_PER_BIT - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES - 1);
  localparam logic [3:0]        STOP_IDX  = 4'(FRAME_BITS - 1);

  function automatic logic [FRAME_BITS-1:0] mkFrame(input logic [7:0] d);
    return {1'b0, d, ~^d, 1'b1};
  endfunction

  linkState_t state;
  ctrlStrobe_t stReg;
  logic [2:0] lineSync;
  logic lineS, prevS;
  logic [CNT_W-1:0] cnt;
  logic [3:0] bitIdx;
  logic [1:0] byteIdx, nBytes;
  logic [FRAME_BITS-1:0] curFrame;
  logic [8:0] rxShift;
  logic rxBad, waiting, slaveMay;
  logic [WAIT_W-1:0] waitCnt;
  logic accept, stopHit, stopBad, gapEnd, frameEnd, frameBad;
  logic [1:0] frameCnt;

  assign lineS = lineSync[1];
  assign prevS = lineSync[2];

  always_comb begin
    accept   = goReq && state == ST_IDLE && (isMaster ? !waiting : slaveMay);
    stopHit  = state == ST_RX && cnt == HALF && bitIdx == STOP_IDX;
    stopBad  = !lineS || !(^rxShift);
    gapEnd   = state == ST_GAP && lineS && cnt == GAP_LAST;
    frameEnd = (stopHit && byteIdx == 2'd2) || gapEnd;
    frameCnt = stopHit ? 2'd3 : byteIdx;
    frameBad = rxBad || (stopHit && stopBad);
    st = stReg;
    st.txStart = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;  lineSync <= 3'b111; lineOut <= 1'b1;
      cnt <= '0; bitIdx <= '0; byteIdx <= '0; nBytes <= '0;
      curFrame <= '1; rxShift <= '0; rxBad <= 1'b0;
      waiting <= 1'b0; waitCnt <= '0; slaveMay <= 1'b0; stReg <= '0;
    end else begin
      lineSync <= {lineSync[1:0], lineIn};
      stReg <= '0;
      if (waiting) begin
        if (waitCnt == WAIT_LAST) begin
          waiting <= 1'b0;
          stReg.timeout <= 1'b1;
        end else waitCnt <= waitCnt + 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_TX; nBytes <= txCountReq; byteIdx <= '0; bitIdx <= '0;
            cnt <= '0; curFrame <= mkFrame(txBytes[0]); lineOut <= 1'b0;
            slaveMay <= 1'b0;
          end else if (prevS && !lineS) begin
            state <= ST_RX; cnt <= CNT_W'(1); bitIdx <= '0; byteIdx <= '0; rxBad <= 1'b0;
          end
        end
        ST_TX: begin
          if (cnt == HALF && curFrame[4'd10 - bitIdx] && !lineS) begin
            stReg.txErr <= 1'b1; lineOut <= 1'b1; state <= ST_IDLE;
          end else if (cnt == BIT_LAST) begin
            cnt <= '0;
            if (bitIdx == STOP_IDX) begin
              if (byteIdx == nBytes - 2'd1) begin
                state <= ST_IDLE; lineOut <= 1'b1;
                if (isMaster) begin waiting <= 1'b1; waitCnt <= '0; end
              end else begin
                byteIdx <= byteIdx + 2'd1; bitIdx <= '0; lineOut <= 1'b0;
                curFrame <= mkFrame(txBytes[byteIdx + 2'd1]);
              end
            end else begin
              bitIdx <= bitIdx + 4'd1;
              lineOut <= curFrame[4'd9 - bitIdx];
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_RX: begin
          if (stopHit) begin
            stReg.rxByteVld <= 1'b1; stReg.rxByteIdx <= byteIdx; stReg.rxByte <= rxShift[8:1];
            if (byteIdx != 2'd2) begin
              state <= ST_GAP; cnt <= '0; byteIdx <= byteIdx + 2'd1;
              rxBad <= rxBad || stopBad;
            end
          end else begin
            if (cnt == HALF) begin
              if (bitIdx == 4'd0) begin
                if (lineS) state <= ST_IDLE;
              end else rxShift <= {rxShift[7:0], lineS};
            end
            if (cnt == BIT_LAST) begin cnt <= '0; bitIdx <= bitIdx + 4'd1; end
            else cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (!lineS) begin
            state <= ST_RX; cnt <= CNT_W'(1); bitIdx <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (frameEnd) begin
        state <= ST_IDLE;
        if (frameBad) stReg.rxErr <= 1'b1;
        else begin
          stReg.rxDone <= 1'b1; stReg.rxCount <= frameCnt;
          slaveMay <= 1'b1; waiting <= 1'b0;
        end
      end
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN) st.txStart |=> !lineOut);
  // R9
  tx_err_release_chk: assert property (@(posedge clk) disable iff (!rstN) stReg.txErr |-> lineOut);
  // R7
  rx_count_chk: assert property (@(posedge clk) disable iff (!rstN) stReg.rxDone |-> stReg.rxCount != 2'd0);
  // R4
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && state == ST_TX) |-> !st.txStart);
endmodule

// File: rtl/plc_link_ctrl.sv
module plc_link_ctrl
  import plc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 3000,
  parameter int WAIT_CYCLES  = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic       busWe,
  input  logic       busRe,
  input  logic [7:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irqN,
  input  logic       lineIn,
  output logic       lineOut
);
  ctrlStrobe_t st;
  logic goReq;
  logic [1:0] txCountReq;
  logic [BYTE_SLOTS-1:0][7:0] txBytes;

  plc_dp u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqN(irqN), .st(st),
    .goReq(goReq), .txCountReq(txCountReq), .txBytes(txBytes)
  );

  plc_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .goReq(goReq),
    .txCountReq(txCountReq), .txBytes(txBytes), .lineIn(lineIn),
    .lineOut(lineOut), .st(st)
  );
endmodule

// File: tb/tb_plc_link_ctrl.sv
module tb_plc_link_ctrl;
  localparam int CPB   = 8;
  localparam int WAITC = 600;

  logic clk = 1'b0, rstN = 1'b0, isMaster = 1'b1;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, busRdata;
  logic irqN, lineOut, peerOut = 1'b1, lineIn;
  int total = 0, bad = 0;
  bit expQ[$];
  bit chkLine = 1'b0;
  logic [7:0] txMirror [3];

  assign lineIn = lineOut & peerOut;

  plc_link_ctrl #(.CLKS_PER_BIT(CPB), .WAIT_CYCLES(WAITC)) dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqN(irqN),
    .lineIn(lineIn), .lineOut(lineOut)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkLine && rstN) begin
      bit e;
      e = (expQ.size() > 0) ? expQ.pop_front() : 1'b1;
      check("R3 line level", lineOut, e);
    end
  end

  task automatic pushFrame(logic [7:0] b);
    logic [10:0] f;
    f = {1'b0, b, ~^b, 1'b1};
    for (int i = 10; i >= 0; i--) repeat (CPB) expQ.push_back(f[i]);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busWe = 1'b0;
    if (a >= 8'h0D && a <= 8'h0F) txMirror[a - 8'h0D] = d;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1 busRe = 1'b0;
  endtask

  task automatic trigger(logic [7:0] v, bit expectGo);
    wr(8'h09, v);
    if (expectGo) for (int i = 0; i < int'(v[1:0]); i++) pushFrame(txMirror[i]);
  endtask

  task automatic peerSend(logic [7:0] b, bit badPar);
    logic [10:0] f;
    f = {1'b0, b, (~^b) ^ badPar, 1'b1};
    for (int i = 10; i >= 0; i--) begin
      @(negedge clk); peerOut = f[i];
      repeat (CPB - 1) @(negedge clk);
    end
  endtask

  task automatic doReset(bit master);
    chkLine = 1'b0; expQ.delete(); peerOut = 1'b1;
    rstN = 1'b0; isMaster = master;
    for (int i = 0; i < 3; i++) txMirror[i] = 8'h00;
    repeat (3) @(posedge clk); #1 rstN = 1'b1;
    chkLine = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    doReset(1'b1);
    // R1 reset state
    check("R1 lineOut", lineOut, 1);
    check("R1 irqN", irqN, 1);
    rd(8'h0B, d); check("R1 flags", d, 0);
    rd(8'h10, d); check("R1 rx0", d, 0);
    rd(8'h0D, d); check("R1 tx0", d, 0);
    rd(8'h09, d); check("R1 ctrl", d, 0);
    rd(8'h0C, d); check("R1 mask", d, 8'h1F);

    // R2 register access
    wr(8'h0D, 8'hA5); wr(8'h0E, 8'h3C); wr(8'h0F, 8'h01);
    rd(8'h0D, d); check("R2 tx0", d, 8'hA5);
    rd(8'h0E, d); check("R2 tx1", d, 8'h3C);
    rd(8'h0F, d); check("R2 tx2", d, 8'h01);
    wr(8'h11, 8'hFF); rd(8'h11, d); check("R2 rx1 write ignored", d, 0);

    // R3 three-byte frame, R4 refusal while busy and while waiting
    trigger(8'hB7, 1'b1);
    rd(8'h09, d); check("R3 cfg readback", d, 8'hB4);
    idle(40);
    trigger(8'h01, 1'b0);          // R4 busy
    idle(260);
    trigger(8'h01, 1'b0);          // R4 waiting
    idle(30);
    check("R4 no frame while waiting", lineOut, 1);

    // R5 timeout
    idle(WAITC);
    check("R10 irqN low on timeout", irqN, 0);
    rd(8'h0B, d); check("R5 timeout flag", d, 8'h01);
    check("R10 irqN released after read", irqN, 1);
    rd(8'h0B, d); check("R10 clear on read", d, 0);
    trigger(8'h01, 1'b1);          // R5 accepted after timeout
    idle(100);

    // R7 two-byte reply, R11 ends wait
    peerSend(8'h12, 1'b0); peerSend(8'h34, 1'b0);
    idle(4 * CPB);
    rd(8'h0B, d); check("R7 count flag 2", d, 8'h04);
    rd(8'h10, d); check("R7 rx0", d, 8'h12);
    rd(8'h11, d); check("R7 rx1", d, 8'h34);
    idle(WAITC + 50);
    rd(8'h0B, d); check("R11 no timeout after reply", d, 0);
    trigger(8'h01, 1'b1);          // R11 accepted
    idle(100 + WAITC);
    rd(8'h0B, d); check("R5 second timeout", d, 8'h01);

    // R7 three-byte reception ends at third stop
    peerSend(8'hC3, 1'b0); peerSend(8'h0F, 1'b0); peerSend(8'hF0, 1'b0);
    idle(CPB);
    rd(8'h0B, d); check("R7 count flag 3", d, 8'h06);
    rd(8'h12, d); check("R7 rx2", d, 8'hF0);

    // R8 parity error
    peerSend(8'h5B, 1'b1);
    idle(4 * CPB);
    rd(8'h0B, d); check("R8 parity error flag", d, 8'h10);

    // R10 masking
    wr(8'h0C, 8'h00);
    peerSend(8'h5A, 1'b0);
    idle(4 * CPB);
    check("R10 masked irqN", irqN, 1);
    wr(8'h0C, 8'h02);
    check("R10 unmasked irqN", irqN, 0);
    rd(8'h0B, d); check("R10 count flag 1", d, 8'h02);
    check("R10 irqN after read", irqN, 1);
    wr(8'h0C, 8'h1F);

    // R9 collision
    doReset(1'b1);
    chkLine = 1'b0;
    wr(8'h0D, 8'h80);
    peerOut = 1'b0;
    trigger(8'h01, 1'b0);
    idle(3 * CPB);
    check("R9 line released", lineOut, 1);
    peerOut = 1'b1;
    idle(4 * CPB);
    rd(8'h0B, d); check("R9 tx error flag", d, 8'h08);
    chkLine = 1'b1;

    // R6 slave gating
    doReset(1'b0);
    wr(8'h0D, 8'h66);
    trigger(8'h01, 1'b0);
    idle(20);
    check("R6 slave refuses first", lineOut, 1);
    peerSend(8'h77, 1'b0);
    idle(4 * CPB);
    rd(8'h0B, d); check("R6 slave got frame", d, 8'h02);
    rd(8'h10, d); check("R7 slave rx0", d, 8'h77);
    trigger(8'h01, 1'b1);
    idle(100);
    trigger(8'h01, 1'b0);
    idle(20);
    check("R6 slave refuses second", lineOut, 1);
    idle(WAITC + 20);
    rd(8'h0B, d); check("R5 slave never times out", d, 0);

    chkLine = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule